// File: doc/BRIEF.md
# Channel-List Scan Sequencer

This block controls the scan of a multi-channel acquisition front end. Over a 16-bit register bus, software loads a list of up to 16 slots. Each slot names a multiplexer channel, a 2-bit gain code and a unipolar flag. Software then programs a first and a last slot index and opens the conversion gate. Each conversion tick starts one conversion on the slot under the scan pointer. The slot's channel, gain and polarity are driven toward the converter, and a one-cycle start pulse is issued. The converter answers with a done pulse and a sample word.

Each sample is pushed into a sample FIFO. Each completed conversion raises a conversion-done pending flag. The conversion on the last slot also raises an end-of-scan flag, and the pointer returns to the first slot. Interrupt enables mask both flags onto one interrupt line. Reading the status register clears the pending flags. Reading one particular address empties the FIFO. An optional external trigger holds off all conversions until it has been seen once.

Top module: `scan_seq`

## Requirements
- R1: A write to address 2 loads slot bits 11:8 with unipolar = bit 7, gain = bits 5:4 and mux channel = bits 3:0. On each conversion start, `conv_go` pulses for one cycle and `mux_sel`, `gain_code` and `unipolar` show that slot's fields until the next start.
- R2: A write to address 0 loads the last index from bits 11:8, the first index from bits 3:0 and the gate from bit 12, and moves the scan pointer to the first index. With scanning on, conversions visit first, first+1, ..., last and then return to first.
- R3: The conversion on the last index sets the end-of-scan pending flag (status bit 13).
- R4: Mode bit 3 (address 1 write) turns scanning on. With scanning off, every conversion uses the first index, and every conversion sets end-of-scan.
- R5: Status bit 15 reads 1 from the start of a conversion until its done pulse, and 0 otherwise.
- R6: Samples are read in arrival order by reading address 0. Status bit 1 reports FIFO empty and bit 2 reports FIFO full. Reading an empty FIFO returns 0.
- R7: A sample arriving at a full FIFO is dropped and sets the sticky overflow bit (status bit 3). A read of address 3 empties the FIFO and clears the overflow bit.
- R8: `irq` is high while (end-of-scan pending and mode bit 1) or (conversion-done pending, status bit 12, and mode bit 0).
- R9: A read of the status register (address 1) returns the flags and clears both pending flags, so `irq` falls.
- R10: When control bit 15 is set, ticks are ignored until `ext_trig` has been seen high. After that, the gate stays armed until the next control write.
- R11: A control write of zero closes the gate and disables the external trigger, so later ticks and trigger pulses start nothing.
- R12: A tick during a conversion is ignored, and a done pulse with no conversion in progress neither stores a sample nor sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| conv_tick | input | 1 | Conversion request from the pacing timer |
| ext_trig | input | 1 | External start trigger |
| adc_done | input | 1 | Converter finished |
| adc_data | input | SAMPLE_W | Converted sample |
| conv_go | output | 1 | Conversion start pulse |
| mux_sel | output | 4 | Multiplexer channel of the active slot |
| gain_code | output | 2 | Gain code of the active slot |
| unipolar | output | 1 | Polarity of the active slot |
| irq | output | 1 | Interrupt request |

## Verification
A tick sampled at a rising edge starts a conversion at that same edge. So `conv_go` and the slot outputs are valid in the cycle right after it. A done pulse updates the FIFO, the pending flags, `irq` and the scan pointer at its own edge. Read data appears in the cycle after the read strobe. The bench drives every input on the falling edge and samples on the falling edge that follows the edge that captured the input. A scoreboard queue holds the expected slot for each start, and any start that appears when the queue is empty counts as a failure.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
  localparam int BUS_W = 16;

  typedef struct packed {
    logic       unipolar;
    logic [1:0] gain;
    logic [3:0] mux;
  } slot_t;

  typedef enum logic [1:0] {
    ADR_DATA = 2'd0,
    ADR_STAT = 2'd1,
    ADR_LIST = 2'd2,
    ADR_FRST = 2'd3
  } reg_adr_e;

  // control word fields
  localparam int CTL_EXT_BIT   = 15;
  localparam int CTL_GATE_BIT  = 12;
  localparam int CTL_LAST_LSB  = 8;
  localparam int CTL_FIRST_LSB = 0;
  // list word fields
  localparam int LST_IDX_LSB   = 8;
  localparam int LST_UNI_BIT   = 7;
  localparam int LST_GAIN_LSB  = 4;
  localparam int LST_MUX_LSB   = 0;
  // mode word fields
  localparam int MOD_SCAN_BIT  = 3;
  localparam int MOD_EOS_BIT   = 1;
  localparam int MOD_EOC_BIT   = 0;
  // status word fields
  localparam int ST_BUSY_BIT   = 15;
  localparam int ST_EOS_BIT    = 13;
  localparam int ST_EOC_BIT    = 12;
  localparam int ST_OVF_BIT    = 3;
  localparam int ST_FULL_BIT   = 2;
  localparam int ST_EMPTY_BIT  = 1;
endpackage

// File: rtl/scan_list_ram.sv
`timescale 1ns/1ps
module scan_list_ram
  import scan_pkg::*;
#(
  parameter int N_SLOTS = 16,
  localparam int IDX_W = $clog2(N_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  slot_t            wr_slot,
  input  logic [IDX_W-1:0] rd_idx,
  output slot_t            rd_slot
);
  slot_t              slots_q [N_SLOTS];
  logic [N_SLOTS-1:0] slot_we;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_we
    assign slot_we[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOTS; i++) slots_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_SLOTS; i++) begin
        if (slot_we[i]) slots_q[i] <= wr_slot;
      end
    end
  end

  assign rd_slot = slots_q[rd_idx];
endmodule

// File: rtl/scan_fifo.sv
`timescale 1ns/1ps
module scan_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty,
  output logic         ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign ovf   = ovf_q;
  assign dout  = mem[rp_q];

  always_comb begin
    pop_ok  = pop && !clr && !empty;
    push_ok = push && !clr && (!full || pop_ok);
    wp_d    = wp_q;
    rp_d    = rp_q;
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (push && !push_ok) ovf_d = 1'b1;
      if (push_ok) wp_d = bump(wp_q);
      if (pop_ok)  rp_d = bump(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end
endmodule

// File: rtl/scan_engine.sv
`timescale 1ns/1ps
module scan_engine
  import scan_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [IDX_W-1:0] ctrl_first,
  input  logic [IDX_W-1:0] ctrl_last,
  input  logic             ctrl_gate,
  input  logic             ctrl_ext,
  input  logic             scan_en,
  input  logic             conv_tick,
  input  logic             ext_trig,
  input  logic             adc_done,
  input  slot_t            slot_rd,
  output logic [IDX_W-1:0] ptr,
  output logic             busy,
  output logic             conv_go,
  output slot_t            slot_cur,
  output logic             done_acc,
  output logic             eos_hit,
  output logic             ext_en,
  output logic             armed
);
  logic [IDX_W-1:0] first_q, first_d, last_q, last_d, ptr_q, ptr_d;
  logic             gate_q, gate_d, ext_q, ext_d, armed_q, armed_d;
  logic             busy_q, busy_d, go_q, go_d;
  slot_t            cur_q, cur_d;
  logic             launch;

  assign done_acc = adc_done && busy_q;
  assign eos_hit  = done_acc && (!scan_en || (ptr_q == last_q));
  assign launch   = conv_tick && gate_q && (!ext_q || armed_q) && !busy_q && !ctrl_wr;

  always_comb begin
    first_d = first_q;
    last_d  = last_q;
    ptr_d   = ptr_q;
    gate_d  = gate_q;
    ext_d   = ext_q;
    armed_d = armed_q;
    busy_d  = busy_q;
    cur_d   = cur_q;
    go_d    = 1'b0;
    if (ext_q && ext_trig) armed_d = 1'b1;
    if (launch) begin
      busy_d = 1'b1;
      go_d   = 1'b1;
      cur_d  = slot_rd;
    end
    if (done_acc) begin
      busy_d = 1'b0;
      ptr_d  = eos_hit ? first_q : ptr_q + IDX_W'(1);
    end
    if (ctrl_wr) begin
      first_d = ctrl_first;
      last_d  = ctrl_last;
      gate_d  = ctrl_gate;
      ext_d   = ctrl_ext;
      ptr_d   = ctrl_first;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      ptr_q   <= '0;
      gate_q  <= 1'b0;
      ext_q   <= 1'b0;
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      go_q    <= 1'b0;
      cur_q   <= '0;
    end else begin
      first_q <= first_d;
      last_q  <= last_d;
      ptr_q   <= ptr_d;
      gate_q  <= gate_d;
      ext_q   <= ext_d;
      armed_q <= armed_d;
      busy_q  <= busy_d;
      go_q    <= go_d;
      cur_q   <= cur_d;
    end
  end

  assign ptr      = ptr_q;
  assign busy     = busy_q;
  assign conv_go  = go_q;
  assign slot_cur = cur_q;
  assign ext_en   = ext_q;
  assign armed    = armed_q;
endmodule

// File: rtl/scan_irq.sv
`timescale 1ns/1ps
module scan_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_wr,
  input  logic mode_scan,
  input  logic mode_eos_ie,
  input  logic mode_eoc_ie,
  input  logic stat_rd,
  input  logic eoc_evt,
  input  logic eos_evt,
  output logic scan_en,
  output logic eoc_pend,
  output logic eos_pend,
  output logic irq
);
  logic scan_q, scan_d, eos_ie_q, eos_ie_d, eoc_ie_q, eoc_ie_d;
  logic eoc_q, eoc_d, eos_q, eos_d;

  always_comb begin
    scan_d   = scan_q;
    eos_ie_d = eos_ie_q;
    eoc_ie_d = eoc_ie_q;
    if (mode_wr) begin
      scan_d   = mode_scan;
      eos_ie_d = mode_eos_ie;
      eoc_ie_d = mode_eoc_ie;
    end
    // a new event in the same cycle as a status read is kept
    eoc_d = eoc_evt ? 1'b1 : (stat_rd ? 1'b0 : eoc_q);
    eos_d = eos_evt ? 1'b1 : (stat_rd ? 1'b0 : eos_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q   <= 1'b0;
      eos_ie_q <= 1'b0;
      eoc_ie_q <= 1'b0;
      eoc_q    <= 1'b0;
      eos_q    <= 1'b0;
    end else begin
      scan_q   <= scan_d;
      eos_ie_q <= eos_ie_d;
      eoc_ie_q <= eoc_ie_d;
      eoc_q    <= eoc_d;
      eos_q    <= eos_d;
    end
  end

  assign scan_en  = scan_q;
  assign eoc_pend = eoc_q;
  assign eos_pend = eos_q;
  assign irq      = (eos_q && eos_ie_q) || (eoc_q && eoc_ie_q);
endmodule

// File: rtl/scan_seq.sv
`timescale 1ns/1ps
module scan_seq
  import scan_pkg::*;
#(
  parameter int N_SLOTS    = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int SAMPLE_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                conv_tick,
  input  logic                ext_trig,
  input  logic                adc_done,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic                conv_go,
  output logic [3:0]          mux_sel,
  output logic [1:0]          gain_code,
  output logic                unipolar,
  output logic                irq
);
  localparam int IDX_W = $clog2(N_SLOTS);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // bus decode
  logic ctrl_wr, mode_wr, list_wr, fifo_pop, stat_rd, fifo_clr;
  assign ctrl_wr  = bus_wr && (bus_addr == ADR_DATA);
  assign mode_wr  = bus_wr && (bus_addr == ADR_STAT);
  assign list_wr  = bus_wr && (bus_addr == ADR_LIST);
  assign fifo_pop = bus_rd && (bus_addr == ADR_DATA);
  assign stat_rd  = bus_rd && (bus_addr == ADR_STAT);
  assign fifo_clr = bus_rd && (bus_addr == ADR_FRST);

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[14:13], bus_wdata[6]};

  slot_t wr_slot;
  assign wr_slot.unipolar = bus_wdata[LST_UNI_BIT];
  assign wr_slot.gain     = bus_wdata[LST_GAIN_LSB +: 2];
  assign wr_slot.mux      = bus_wdata[LST_MUX_LSB +: 4];

  logic [IDX_W-1:0] ptr;
  slot_t            slot_rd, slot_cur;
  logic             busy, done_acc, eos_hit, ext_en, armed, scan_en;
  logic             eoc_pend, eos_pend;
  logic             fifo_full, fifo_empty, fifo_ovf;
  logic [SAMPLE_W-1:0] fifo_dout;

  scan_list_ram #(.N_SLOTS(N_SLOTS)) u_list (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (list_wr),
    .wr_idx  (bus_wdata[LST_IDX_LSB +: IDX_W]),
    .wr_slot (wr_slot),
    .rd_idx  (ptr),
    .rd_slot (slot_rd)
  );

  scan_engine #(.IDX_W(IDX_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_first (bus_wdata[CTL_FIRST_LSB +: IDX_W]),
    .ctrl_last  (bus_wdata[CTL_LAST_LSB +: IDX_W]),
    .ctrl_gate  (bus_wdata[CTL_GATE_BIT]),
    .ctrl_ext   (bus_wdata[CTL_EXT_BIT]),
    .scan_en    (scan_en),
    .conv_tick  (conv_tick),
    .ext_trig   (ext_trig),
    .adc_done   (adc_done),
    .slot_rd    (slot_rd),
    .ptr        (ptr),
    .busy       (busy),
    .conv_go    (conv_go),
    .slot_cur   (slot_cur),
    .done_acc   (done_acc),
    .eos_hit    (eos_hit),
    .ext_en     (ext_en),
    .armed      (armed)
  );

  scan_fifo #(.DEPTH(FIFO_DEPTH), .W(SAMPLE_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (done_acc),
    .pop   (fifo_pop),
    .clr   (fifo_clr),
    .din   (adc_data),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty),
    .ovf   (fifo_ovf)
  );

  scan_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .mode_wr     (mode_wr),
    .mode_scan   (bus_wdata[MOD_SCAN_BIT]),
    .mode_eos_ie (bus_wdata[MOD_EOS_BIT]),
    .mode_eoc_ie (bus_wdata[MOD_EOC_BIT]),
    .stat_rd     (stat_rd),
    .eoc_evt     (done_acc),
    .eos_evt     (eos_hit),
    .scan_en     (scan_en),
    .eoc_pend    (eoc_pend),
    .eos_pend    (eos_pend),
    .irq         (irq)
  );

  // status word
  logic [BUS_W-1:0] status;
  always_comb begin
    status               = '0;
    status[ST_BUSY_BIT]  = busy;
    status[ST_EOS_BIT]   = eos_pend;
    status[ST_EOC_BIT]   = eoc_pend;
    status[ST_OVF_BIT]   = fifo_ovf;
    status[ST_FULL_BIT]  = fifo_full;
    status[ST_EMPTY_BIT] = fifo_empty;
  end

  // registered read data
  logic [BUS_W-1:0] rdata_q, rdata_d;
  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      case (bus_addr)
        ADR_DATA: rdata_d = fifo_empty ? '0 : BUS_W'(fifo_dout);
        ADR_STAT: rdata_d = status;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign mux_sel   = slot_cur.mux;
  assign gain_code = slot_cur.gain;
  assign unipolar  = slot_cur.unipolar;
endmodule

// File: rtl/scan_seq_chk.sv
`timescale 1ns/1ps
module scan_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_go,
  input logic [3:0] mux_sel,
  input logic [1:0] gain_code,
  input logic       unipolar,
  input logic       busy,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       fifo_ovf,
  input logic       fifo_clr,
  input logic       stat_rd,
  input logic       done_acc,
  input logic       irq,
  input logic       ext_en,
  input logic       armed
);
  assert_go_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> !conv_go);

  assert_slot_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_go) |-> $stable({unipolar, gain_code, mux_sel}));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ovf && !fifo_clr) |=> fifo_ovf);

  assert_clr_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fifo_empty && !fifo_ovf));

  assert_stat_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done_acc) |=> !irq);

  assert_ext_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && !armed) |=> !conv_go);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> !busy);
endmodule

bind scan_seq scan_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .conv_go    (conv_go),
  .mux_sel    (mux_sel),
  .gain_code  (gain_code),
  .unipolar   (unipolar),
  .busy       (busy),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .fifo_ovf   (fifo_ovf),
  .fifo_clr   (fifo_clr),
  .stat_rd    (stat_rd),
  .done_acc   (done_acc),
  .irq        (irq),
  .ext_en     (ext_en),
  .armed      (armed)
);

// File: tb/scan_seq_bench.sv
`timescale 1ns/1ps
module scan_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        conv_tick, ext_trig, adc_done;
  logic [15:0] adc_data;
  logic        conv_go, unipolar, irq;
  logic [3:0]  mux_sel;
  logic [1:0]  gain_code;

  always #10 clk = ~clk;

  scan_seq u_scan_seq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_tick(conv_tick), .ext_trig(ext_trig), .adc_done(adc_done),
    .adc_data(adc_data), .conv_go(conv_go), .mux_sel(mux_sel),
    .gain_code(gain_code), .unipolar(unipolar), .irq(irq)
  );

  int n_checks = 0;
  int n_errors = 0;
  logic [6:0] exp_q [$];
  logic [6:0] bench_list [16];
  logic [6:0] mon_exp;
  logic [15:0] rv;

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every start must match the next expected slot
  always @(negedge clk) begin
    if (rst_n === 1'b1 && conv_go === 1'b1) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R12 unexpected start actual=%h expected=none",
                 {unipolar, gain_code, mux_sel});
      end else begin
        mon_exp = exp_q.pop_front();
        if ({unipolar, gain_code, mux_sel} !== mon_exp) begin
          n_errors++;
          $display("FAIL R1/R2 slot outputs actual=%h expected=%h",
                   {unipolar, gain_code, mux_sel}, mon_exp);
        end
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic load_slot(input int s, input logic u, input logic [1:0] g, input logic [3:0] m);
    bench_list[s] = {u, g, m};
    bus_write(2'd2, {4'h0, 4'(s), u, 1'b0, g, m});
  endtask

  task automatic convert(input int s, input logic [15:0] d);
    exp_q.push_back(bench_list[s]);
    @(negedge clk); conv_tick = 1'b1;
    @(negedge clk); conv_tick = 1'b0; adc_done = 1'b1; adc_data = d;
    @(negedge clk); adc_done = 1'b0;
  endtask

  task automatic tick_only();
    @(negedge clk); conv_tick = 1'b1;
    @(negedge clk); conv_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    conv_tick = 1'b0; ext_trig = 1'b0; adc_done = 1'b0; adc_data = '0;
    for (int i = 0; i < 16; i++) bench_list[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    check16("R5 irq at reset", {15'h0, irq}, 16'h0);
    check16("R1 conv_go at reset", {15'h0, conv_go}, 16'h0);
    bus_read(2'd1, rv); check16("R6 reset status", rv, 16'h0002);

    load_slot(0, 1'b0, 2'd1, 4'd5);
    load_slot(1, 1'b1, 2'd2, 4'd9);
    load_slot(2, 1'b0, 2'd3, 4'd3);
    load_slot(3, 1'b1, 2'd0, 4'd12);

    // scan 0..2 with both interrupts on
    bus_write(2'd1, 16'h000B);
    bus_write(2'd0, 16'h1200);
    convert(0, 16'h0100);
    check16("R8 irq on conversion done", {15'h0, irq}, 16'h1);
    bus_read(2'd1, rv); check16("R9 status after first conversion", rv, 16'h1000);
    check16("R9 irq cleared by status read", {15'h0, irq}, 16'h0);
    convert(1, 16'h0101);
    convert(2, 16'h0102);
    bus_read(2'd1, rv); check16("R3 end of scan on last index", rv, 16'h3000);
    convert(0, 16'h0103);
    bus_read(2'd1, rv); check16("R2 wrap conversion no end of scan", rv, 16'h1000);
    for (int i = 0; i < 4; i++) begin
      bus_read(2'd0, rv); check16("R6 fifo order", rv, 16'h0100 + 16'(i));
    end
    bus_read(2'd1, rv); check16("R6 fifo empty flag", rv, 16'h0002);
    bus_read(2'd0, rv); check16("R6 empty read returns zero", rv, 16'h0000);

    // busy flag, tick during conversion, done while idle
    exp_q.push_back(bench_list[1]);
    @(negedge clk); conv_tick = 1'b1;
    @(negedge clk); conv_tick = 1'b0;
    bus_read(2'd1, rv); check16("R5 busy during conversion", rv, 16'h8002);
    tick_only();
    @(negedge clk); adc_done = 1'b1; adc_data = 16'h0200;
    @(negedge clk); adc_done = 1'b0;
    bus_read(2'd1, rv); check16("R5 busy cleared after done", rv, 16'h1000);
    @(negedge clk); adc_done = 1'b1; adc_data = 16'h0BAD;
    @(negedge clk); adc_done = 1'b0;
    bus_read(2'd1, rv); check16("R12 idle done sets nothing", rv, 16'h0000);
    bus_read(2'd0, rv); check16("R12 only real sample stored", rv, 16'h0200);
    bus_read(2'd1, rv); check16("R12 no idle sample stored", rv, 16'h0002);

    // rewrite control mid-scan: first 1, last 3
    bus_write(2'd0, 16'h1301);
    convert(1, 16'h0400);
    convert(2, 16'h0401);
    convert(3, 16'h0402);
    convert(1, 16'h0403);
    bus_read(2'd1, rv); check16("R3 end of scan at index 3", rv, 16'h3000);
    bus_read(2'd0, rv); check16("R2 first sample of new range", rv, 16'h0400);
    bus_read(2'd3, rv);
    bus_read(2'd1, rv); check16("R7 fifo reset read", rv, 16'h0002);

    // scanning off: first index repeats, every conversion ends a scan
    bus_write(2'd1, 16'h0003);
    bus_write(2'd0, 16'h1302);
    convert(2, 16'h0500);
    bus_read(2'd1, rv); check16("R4 single entry ends scan", rv, 16'h3000);
    convert(2, 16'h0501);
    bus_read(2'd1, rv); check16("R4 repeat of single entry", rv, 16'h3000);
    bus_read(2'd3, rv);

    // end-of-scan interrupt only
    bus_write(2'd1, 16'h000A);
    bus_write(2'd0, 16'h1100);
    convert(0, 16'h0600);
    check16("R8 masked conversion-done irq", {15'h0, irq}, 16'h0);
    convert(1, 16'h0601);
    check16("R8 end-of-scan irq", {15'h0, irq}, 16'h1);
    bus_read(2'd1, rv); check16("R9 status with both pending", rv, 16'h3000);
    check16("R9 irq cleared", {15'h0, irq}, 16'h0);
    bus_read(2'd3, rv);

    // overflow
    bus_write(2'd1, 16'h0000);
    bus_write(2'd0, 16'h1000);
    for (int i = 0; i < 17; i++) convert(0, 16'h0300 + 16'(i));
    check16("R8 all masked", {15'h0, irq}, 16'h0);
    bus_read(2'd1, rv); check16("R7 full and overflow", rv, 16'h300C);
    bus_read(2'd0, rv); check16("R7 oldest sample kept", rv, 16'h0300);
    bus_read(2'd1, rv); check16("R7 overflow sticky", rv, 16'h0008);
    bus_read(2'd3, rv);
    bus_read(2'd1, rv); check16("R7 reset clears overflow", rv, 16'h0002);

    // external trigger
    bus_write(2'd0, 16'h9000);
    tick_only();
    bus_read(2'd1, rv); check16("R10 tick held before trigger", rv, 16'h0002);
    ext_pulse();
    convert(0, 16'h0700);
    convert(0, 16'h0701);
    bus_read(2'd1, rv); check16("R10 armed after trigger", rv, 16'h3000);

    // control zero stops everything
    bus_write(2'd0, 16'h0000);
    tick_only();
    ext_pulse();
    tick_only();
    bus_read(2'd1, rv); check16("R11 gate closed after zero write", rv, 16'h0000);
    bus_read(2'd0, rv); check16("R11 earlier samples intact", rv, 16'h0700);

    repeat (3) @(negedge clk);
    check16("R12 all expected starts seen", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule